// File: doc/BRIEF.md
# Address-Based Security Attribution Unit

This block classifies every 32-bit physical address presented to it. From the top nibble of the address it derives a region number, whether the address is non-secure, and whether it may be entered as a non-secure-callable gateway. It also flags the system-area windows that are exempt from security checking. All of these outputs are combinational from the address and from a small configuration register.

Software programs that register through a one-cycle write port. Two of its bits each grant non-secure-callable status to one secure region.

The block also resolves three mirrored address windows. An access to a mirror reports the physical address it aliases, together with a hit flag, so that a downstream decoder can route it. A parameterised list of control-register windows inside the mirrors is not remapped: those windows keep their own address.

Top module: `sec_attr_unit`

## Requirements
- R1: `region_id` equals address bits [31:28] for every address.
- R2: `is_ns` is 1 when address bit 28 is 0, and 0 when address bit 28 is 1.
- R3: `is_nsc` is 1 only for region 1 with configuration bit 0 set, or for region 3 with configuration bit 1 set. It is 0 for every other region and configuration.
- R4: `is_exempt` is 1 exactly for addresses 0xE0000000–0xE00FFFFF and 0xF0000000–0xF00FFFFF. Equivalently, the address masked with 0xEFF00000 equals 0xE0000000.
- R5: After a synchronous active-low reset the configuration is 0, and `cfg_rd_data` reads 0.
- R6: A write with `cfg_wr_en` high stores `cfg_wr_data[1:0]` at the next rising clock edge, and no earlier. Bits [31:2] of the write data are dropped, and `cfg_rd_data[31:2]` always reads 0. Without a write the configuration holds.
- R7: For addresses in regions 1, 3 and 5 outside the exception windows, `alias_hit` is 1 and `phys_addr` equals the address with bit 28 cleared.
- R8: The windows 0x50080000–0x50080FFF and 0x50083000–0x50083FFF are not remapped. For them `alias_hit` is 0 and `phys_addr` equals the address.
- R9: Addresses in every region other than 1, 3 and 5 give `alias_hit` 0 and `phys_addr` equal to the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 32 | Configuration write data; only [1:0] is kept |
| cfg_rd_data | output | 32 | Current configuration, zero-extended |
| addr | input | 32 | Address to classify |
| region_id | output | 4 | Region number (address top nibble) |
| is_ns | output | 1 | Address is non-secure |
| is_nsc | output | 1 | Address is non-secure-callable |
| is_exempt | output | 1 | Address is exempt from security checking |
| alias_hit | output | 1 | Address lies in a mirror and is remapped |
| phys_addr | output | 32 | Resolved physical address |

## Verification
The hardest situation to reach is the interplay between the registered configuration and the combinational outputs. A gateway grant must appear in the first cycle after a write and not in the cycle of the write itself. To cover it, the bench writes each of the four configuration values with junk in the upper bits and checks the cycle of the write as well as the cycle after it. It then sweeps all sixteen regions under that setting. The exemption and exception windows are probed one address inside and one address outside each edge, because a wrong mask bit shows up only at those edges.

// File: rtl/sau_pkg.sv
// Shared widths and the attribute bundle for the security attribution unit.
// Assumes a flat 32-bit physical address space split into 16 regions.
package sau_pkg;
    localparam int ADDR_W = 32;
    localparam int REG_W  = 4;
    localparam int CFG_W  = 2;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [REG_W-1:0] region;
        logic             ns;
        logic             nsc;
        logic             exempt;
    } attr_t;
endpackage

// File: rtl/sau_cfg_reg.sv
// Gateway-enable configuration register.
// Stores the low CFG_W bits of a write and returns them zero-extended.
// Assumes one write per strobe cycle and no read side effects.
module sau_cfg_reg #(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - CFG_W;

    // Capture the low bits of a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wr_data[CFG_W-1:0];
    end

    // Zero-extend the stored bits onto the read bus.
    always_comb rd_data = {{PAD_W{1'b0}}, cfg_q};

    // R6: a write is visible in the next cycle.
    p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cfg_q == $past(wr_data[CFG_W-1:0]));

    // R6: no write means the configuration holds.
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/sau_attr_decode.sv
// Combinational security attribution from the address top nibble.
// Each configuration bit grants gateway status to one listed region.
// Assumes NSC_LIST holds CFG_W region numbers, bit k's region at slot k.
module sau_attr_decode
    import sau_pkg::*;
#(
    parameter int                        AW          = 32,
    parameter int                        RW          = 4,
    parameter int                        CW          = 2,
    parameter logic [CW*RW-1:0]          NSC_LIST    = {4'd3, 4'd1},
    parameter logic [AW-1:0]             EXEMPT_MASK = 32'hEFF0_0000,
    parameter logic [AW-1:0]             EXEMPT_VAL  = 32'hE000_0000
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] cfg,
    output attr_t         attr
);
    localparam int TOP = AW - RW;

    logic [RW-1:0] region;
    logic [CW-1:0] grant;

    // Region number is the top address nibble.
    always_comb region = addr[AW-1:TOP];

    // One gateway grant term per configuration bit.
    for (genvar k = 0; k < CW; k++) begin : g_grant
        always_comb grant[k] = cfg[k] && (region == NSC_LIST[k*RW +: RW]);
    end

    // Assemble the attribute bundle.
    always_comb begin
        attr.region = region;
        attr.ns     = ~region[0];
        attr.nsc    = |grant;
        attr.exempt = (addr & EXEMPT_MASK) == EXEMPT_VAL;
    end

    // R3: a gateway grant is only ever given to a secure address.
    always_comb begin
        if (attr.nsc) begin
            p_nsc_secure_r3: assert (addr[TOP] == 1'b1);
        end
    end

    // R4: exemption only in the top two regions.
    always_comb begin
        if (attr.exempt) begin
            p_exempt_top_r4: assert (addr[AW-1:AW-3] == 3'b111);
        end
    end
endmodule

// File: rtl/sau_alias_remap.sv
// Mirror resolution: a mirrored region maps onto its lower-numbered twin
// by clearing the region LSB, except inside listed exception windows.
// Assumes windows are given as base/mask pairs packed LSB-first.
module sau_alias_remap #(
    parameter int                    AW        = 32,
    parameter int                    RW        = 4,
    parameter logic [(1<<RW)-1:0]    MIRRORS   = 16'h002A,
    parameter int                    NUM_EXCL  = 2,
    parameter logic [NUM_EXCL*AW-1:0] EXCL_BASE = {32'h5008_3000, 32'h5008_0000},
    parameter logic [NUM_EXCL*AW-1:0] EXCL_MASK = {32'hFFFF_F000, 32'hFFFF_F000}
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] phys
);
    localparam int          ALIAS_BIT = AW - RW;
    localparam logic [AW-1:0] CLR     = ~(AW'(1) << ALIAS_BIT);

    logic [NUM_EXCL-1:0] excl;
    logic                mirrored;

    // Match each exception window.
    for (genvar i = 0; i < NUM_EXCL; i++) begin : g_excl
        always_comb excl[i] =
            (addr & EXCL_MASK[i*AW +: AW]) == EXCL_BASE[i*AW +: AW];
    end

    // Look up whether the region is a mirror.
    always_comb mirrored = MIRRORS[addr[AW-1:ALIAS_BIT]];

    // Remap unless an exception window claims the address.
    always_comb begin
        hit  = mirrored && !(|excl);
        phys = hit ? (addr & CLR) : addr;
    end

    // R7: a remapped address lands in the twin region below.
    always_comb begin
        if (hit) begin
            p_alias_clear_r7: assert (phys[ALIAS_BIT] == 1'b0 &&
                                      phys[AW-1:ALIAS_BIT+1] == addr[AW-1:ALIAS_BIT+1]);
        end
    end

    // R8 / R9: without a hit the address passes through untouched.
    always_comb begin
        if (!hit) begin
            p_pass_through_r8: assert (phys == addr);
        end
    end
endmodule

// File: rtl/sec_attr_unit.sv
// Top of the security attribution unit: configuration register,
// attribute decode and mirror remap. Outputs other than the read bus
// are combinational from addr and the registered configuration.
module sec_attr_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic [31:0] addr,
    output logic [3:0]  region_id,
    output logic        is_ns,
    output logic        is_nsc,
    output logic        is_exempt,
    output logic        alias_hit,
    output logic [31:0] phys_addr
);
    import sau_pkg::*;

    logic [CFG_W-1:0] cfg;
    attr_t            attr;

    sau_cfg_reg #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_q   (cfg),
        .rd_data (cfg_rd_data)
    );

    sau_attr_decode #(.AW(ADDR_W), .RW(REG_W), .CW(CFG_W)) u_dec (
        .addr (addr),
        .cfg  (cfg),
        .attr (attr)
    );

    sau_alias_remap #(.AW(ADDR_W), .RW(REG_W)) u_remap (
        .addr (addr),
        .hit  (alias_hit),
        .phys (phys_addr)
    );

    // Unpack the attribute bundle onto the ports.
    always_comb begin
        region_id = attr.region;
        is_ns     = attr.ns;
        is_nsc    = attr.nsc;
        is_exempt = attr.exempt;
    end
endmodule

// File: tb/test_sec_attr_unit.sv
module test_sec_attr_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_wr_en = 0;
    logic [31:0] cfg_wr_data = 0;
    logic [31:0] cfg_rd_data;
    logic [31:0] addr = 0;
    logic [3:0]  region_id;
    logic        is_ns, is_nsc, is_exempt, alias_hit;
    logic [31:0] phys_addr;

    int total = 0;
    int bad   = 0;
    bit chk_en = 0;
    int m_cfg = 0;

    always #10 clk = ~clk;

    sec_attr_unit i_sec_attr_unit (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .addr(addr), .region_id(region_id),
        .is_ns(is_ns), .is_nsc(is_nsc), .is_exempt(is_exempt),
        .alias_hit(alias_hit), .phys_addr(phys_addr)
    );

    // Reference configuration: behavioural, updated at the clock edge.
    always @(posedge clk) begin
        if (!rst_n)         m_cfg <= 0;
        else if (cfg_wr_en) m_cfg <= int'(cfg_wr_data % 4);
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
        end
    endtask

    // Compare every output against the model in each cycle.
    always @(negedge clk) begin
        if (chk_en) begin
            longint a;
            int     r;
            bit     in_excl, mir;
            a = longint'(addr);
            r = int'(a / 64'h1000_0000);
            in_excl = (a >= 64'h5008_0000 && a <= 64'h5008_0FFF) ||
                      (a >= 64'h5008_3000 && a <= 64'h5008_3FFF);
            mir = (r == 1 || r == 3 || r == 5) && !in_excl;
            check("R1", region_id, r);
            check("R2", is_ns, (r % 2 == 0) ? 1 : 0);
            check("R3", is_nsc, ((r == 1 && m_cfg % 2 == 1) || (r == 3 && m_cfg >= 2)) ? 1 : 0);
            check("R4", is_exempt, ((a >= 64'hE000_0000 && a <= 64'hE00F_FFFF) ||
                                    (a >= 64'hF000_0000 && a <= 64'hF00F_FFFF)) ? 1 : 0);
            check("R5/R6", cfg_rd_data, m_cfg);
            check(in_excl ? "R8" : (mir ? "R7" : "R9"), alias_hit, mir ? 1 : 0);
            check(in_excl ? "R8" : (mir ? "R7" : "R9"), phys_addr, mir ? a - 64'h1000_0000 : a);
        end
    end

    task automatic put(input logic [31:0] a);
        @(posedge clk); #1 addr = a;
    endtask

    task automatic write_cfg(input logic [31:0] d);
        @(posedge clk); #1 cfg_wr_en = 1; cfg_wr_data = d;
        // R6: in the write cycle the old value is still in force.
        @(negedge clk) check("R6", cfg_rd_data, m_cfg);
        @(posedge clk); #1 cfg_wr_en = 0; cfg_wr_data = 32'hFFFF_FFFF;
        @(negedge clk) check("R6", cfg_rd_data, longint'(d[1:0]));
    endtask

    initial begin
        #4_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk_en = 1;
        // R5: reset state reads zero.
        @(negedge clk) check("R5", cfg_rd_data, 0);
        for (int c = 0; c < 4; c++) begin
            write_cfg(32'hDEAD_BEE0 | 32'(c));
            for (int r = 0; r < 16; r++) begin
                put({4'(r), 28'h012_3456});
                put({4'(r), 28'h000_0000});
                put({4'(r), 28'hFFF_FFFF});
            end
        end
        // R4: exemption window edges.
        put(32'hDFFF_FFFF); put(32'hE000_0000); put(32'hE00F_FFFF); put(32'hE010_0000);
        put(32'hEFFF_FFFF); put(32'hF000_0000); put(32'hF00F_FFFF); put(32'hF010_0000);
        put(32'hFFFF_FFFF);
        // R8: exception window edges inside the mirror.
        put(32'h5007_FFFF); put(32'h5008_0000); put(32'h5008_0FFF); put(32'h5008_1000);
        put(32'h5008_2FFF); put(32'h5008_3000); put(32'h5008_3FFF); put(32'h5008_4000);
        put(32'h4008_0000); put(32'h1008_0000);
        // R6: a write with a held strobe and then reset again.
        write_cfg(32'h0000_0002);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk) check("R5", cfg_rd_data, 0);
        put(32'h3000_0000);
        @(negedge clk);
        chk_en = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule